// File: doc/BRIEF.md
# Variable-Page-Size Translation Lookaside Buffer

This block translates 64-bit virtual addresses to physical addresses through a fully associative table of tag and translation-entry pairs. Each entry has its own page-size code, so pages of 8 KB, 64 KB, 512 KB and 4 MB can sit side by side in the same table. A lookup compares the current context number and the masked virtual tag against every entry at once. The lowest-indexed match is then checked for validity, privilege and write rights. The outcome is a hit with a physical address and access rights, a miss, or a protection fault.

On a protection fault the block records the cause in a sticky status word and captures the faulting address. If an earlier fault has not been cleared, an overflow flag is raised. Software clears the status word through a dedicated strobe. Entries are loaded by index through an entry-write port and can be read back combinationally. When translation is switched off, the virtual address passes straight through with full rights. Setting the parameter `CHECK_WRITE` to 0 builds an instruction-side variant: the write-permission check is dropped and a hit grants execute rights only.

Response control is a two-state machine. `ST_IDLE` moves to `ST_RESP` when `req_valid` is high. `ST_RESP` stays in `ST_RESP` on a back-to-back request and returns to `ST_IDLE` when no request arrives. A response is presented while the machine is in `ST_RESP`.

Top module: `vpt_tlb`

## Requirements
- R1: A request sampled on a clock edge produces its result registered at that edge: `rsp_valid` is high in the following cycle only. Exactly one of `rsp_hit`, `rsp_miss` and `rsp_fault` is high while `rsp_valid` is high, and all three are low otherwise.
- R2: Translation-entry bits 62:61 select the page size: code 0 is 8 KB, 1 is 64 KB, 2 is 512 KB and 3 is 4 MB. The match ignores the low 13, 16, 19 or 22 address bits respectively. Tag bits 12:0 must equal `cur_ctx`, and the remaining tag bits must equal the masked virtual address.
- R3: On an enabled hit, `rsp_paddr` bits 40:12 take the entry's bits above the page boundary and the virtual address bits below it. `rsp_paddr` bits 63:41 and 11:0 are zero.
- R4: When several entries match, the lowest index decides the outcome, even when that entry faults and a higher one would not.
- R5: A data-side hit sets `rsp_rd_ok`. It sets `rsp_wr_ok` only when translation-entry bit 1 is set.
- R6: A matching entry faults if bit 63 (valid) is clear, if bit 2 (privileged only) is set for a user access, or, on the data side, if bit 1 is clear for a write.
- R7: On a fault, the status word `fsr_q` gains bit 0, bit 2 (write) and bit 3 (user), and `far_q` captures the virtual address.
- R8: If `fsr_q` is nonzero when a fault is recorded, it is first replaced by 2 (overflow) before the fault bits are ORed in.
- R9: A miss, a hit and an idle cycle leave `fsr_q` and `far_q` unchanged.
- R10: With `xlat_en` low, a request hits with `rsp_paddr` equal to the virtual address and full read/write rights. No fault or miss is reported and the fault registers do not change.
- R11: `fsr_clr` zeroes `fsr_q`. If a fault is recorded in the same cycle, it is applied to the cleared value, so no overflow is flagged.
- R12: An entry written on one edge is used by requests sampled on the next edge. A request sampled on the same edge as the write sees the old contents.
- R13: Translation-entry bit 6 (lock) is stored and returned on `ent_rd_tte` but does not alter lookup results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xlat_en | input | 1 | Translation enable |
| cur_ctx | input | 13 | Current context number |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 64 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| rsp_valid | output | 1 | Result valid |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No entry matched |
| rsp_fault | output | 1 | Protection fault |
| rsp_paddr | output | 64 | Physical address |
| rsp_rd_ok | output | 1 | Read granted |
| rsp_wr_ok | output | 1 | Write granted |
| rsp_ex_ok | output | 1 | Execute granted (instruction variant) |
| ent_we | input | 1 | Entry write strobe |
| ent_idx | input | 6 | Entry index to write |
| ent_tag | input | 64 | Tag word to write |
| ent_tte | input | 64 | Translation-entry word to write |
| ent_rd_idx | input | 6 | Entry index to read back |
| ent_rd_tag | output | 64 | Tag word at `ent_rd_idx` |
| ent_rd_tte | output | 64 | Translation-entry word at `ent_rd_idx` |
| fsr_clr | input | 1 | Clear fault status |
| fsr_q | output | 4 | Fault status word |
| far_q | output | 64 | Fault address |

## Verification
Some rules are checked by assertions on every cycle. These are the response timing and the one-outcome rule, the logging of each fault into the status and address registers, the overflow flag on a repeated fault, the holding of the fault registers when nothing touches them, the effect of a clear, and the pass-through behaviour when translation is off. Other behaviour can only be shown by the directed scenarios. This covers the page-size masks, the exact physical address for each page size, lowest-index priority (including a faulting winner), the exact status codes, the ordering of an entry write against a lookup, and the lock bit having no effect.

// File: rtl/vpt_tlb_pkg.sv
package vpt_tlb_pkg;

    localparam int VA_W    = 64;
    localparam int CTX_W   = 13;
    localparam int FSR_W   = 4;

    // translation-entry field positions
    localparam int TTE_VALID = 63;
    localparam int TTE_SZ_HI = 62;
    localparam int TTE_SZ_LO = 61;
    localparam int TTE_LOCK  = 6;
    localparam int TTE_PRIV  = 2;
    localparam int TTE_WRITE = 1;

    // physical address field kept from either source: bits 40:12
    localparam logic [VA_W-1:0] PA_KEEP = 64'h0000_01FF_FFFF_F000;

    typedef enum logic [1:0] {
        PG_8K   = 2'd0,
        PG_64K  = 2'd1,
        PG_512K = 2'd2,
        PG_4M   = 2'd3
    } pg_size_e;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rsp_state_e;

    function automatic logic [VA_W-1:0] page_mask(input pg_size_e sz);
        logic [VA_W-1:0] m;
        unique case (sz)
            PG_8K:   m = 64'hFFFF_FFFF_FFFF_E000;
            PG_64K:  m = 64'hFFFF_FFFF_FFFF_0000;
            PG_512K: m = 64'hFFFF_FFFF_FFF8_0000;
            PG_4M:   m = 64'hFFFF_FFFF_FFC0_0000;
            default: m = 64'hFFFF_FFFF_FFFF_E000;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/vpt_tlb_match.sv
module vpt_tlb_match
    import vpt_tlb_pkg::*;
(
    input  logic [VA_W-1:0]  tag,
    input  logic [1:0]       size_code,
    input  logic [VA_W-1:0]  vaddr,
    input  logic [CTX_W-1:0] ctx,
    output logic             hit
);
    logic [VA_W-1:0] mask;
    logic            ctx_eq;
    logic            va_eq;

    always_comb begin
        mask   = page_mask(pg_size_e'(size_code));
        ctx_eq = (tag[CTX_W-1:0] == ctx);
        va_eq  = ((vaddr & mask) == {tag[VA_W-1:CTX_W], {CTX_W{1'b0}}});
        hit    = ctx_eq && va_eq;
    end
endmodule

// File: rtl/vpt_tlb_prio.sv
module vpt_tlb_prio #(
    parameter int N_ENT = 64,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic [N_ENT-1:0] match_vec,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = |match_vec;
        idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (match_vec[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/vpt_tlb_fault_regs.sv
module vpt_tlb_fault_regs
    import vpt_tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             fault_evt,
    input  logic             is_user,
    input  logic             is_write,
    input  logic [VA_W-1:0]  vaddr,
    output logic [FSR_W-1:0] fsr_q,
    output logic [VA_W-1:0]  far_q
);
    logic [FSR_W-1:0] fsr_base;
    logic [FSR_W-1:0] fsr_d;
    logic [VA_W-1:0]  far_d;

    always_comb begin
        fsr_base = clr ? '0 : fsr_q;
        fsr_d    = fsr_base;
        far_d    = far_q;
        if (fault_evt) begin
            fsr_d = (fsr_base != '0) ? FSR_W'(2) : '0;
            fsr_d = fsr_d | {is_user, is_write, 1'b0, 1'b1};
            far_d = vaddr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsr_q <= '0;
            far_q <= '0;
        end else begin
            fsr_q <= fsr_d;
            far_q <= far_d;
        end
    end

    assert_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_evt && !clr && fsr_q != '0) |=> fsr_q[1]);

    assert_status_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_evt && !clr) |=> ($stable(fsr_q) && $stable(far_q)));

    assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !fault_evt) |=> (fsr_q == '0));
endmodule

// File: rtl/vpt_tlb.sv
module vpt_tlb
    import vpt_tlb_pkg::*;
#(
    parameter int N_ENT       = 64,
    parameter bit CHECK_WRITE = 1'b1,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xlat_en,
    input  logic [12:0]      cur_ctx,
    input  logic             req_valid,
    input  logic [63:0]      req_vaddr,
    input  logic             req_write,
    input  logic             req_user,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic             rsp_fault,
    output logic [63:0]      rsp_paddr,
    output logic             rsp_rd_ok,
    output logic             rsp_wr_ok,
    output logic             rsp_ex_ok,
    input  logic             ent_we,
    input  logic [IDX_W-1:0] ent_idx,
    input  logic [63:0]      ent_tag,
    input  logic [63:0]      ent_tte,
    input  logic [IDX_W-1:0] ent_rd_idx,
    output logic [63:0]      ent_rd_tag,
    output logic [63:0]      ent_rd_tte,
    input  logic             fsr_clr,
    output logic [3:0]       fsr_q,
    output logic [63:0]      far_q
);
    logic [VA_W-1:0] tag_all [N_ENT];
    logic [VA_W-1:0] tte_all [N_ENT];
    logic [N_ENT-1:0] match_vec;

    // ---------------- entry storage and per-entry compare ----------------
    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        logic [VA_W-1:0] tag_q;
        logic [VA_W-1:0] tte_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tag_q <= '0;
                tte_q <= '0;
            end else if (ent_we && ent_idx == IDX_W'(i)) begin
                tag_q <= ent_tag;
                tte_q <= ent_tte;
            end
        end

        assign tag_all[i] = tag_q;
        assign tte_all[i] = tte_q;

        vpt_tlb_match u_match (
            .tag       (tag_q),
            .size_code (tte_q[TTE_SZ_HI:TTE_SZ_LO]),
            .vaddr     (req_vaddr),
            .ctx       (cur_ctx),
            .hit       (match_vec[i])
        );
    end

    assign ent_rd_tag = tag_all[ent_rd_idx];
    assign ent_rd_tte = tte_all[ent_rd_idx];

    // ---------------- priority select ----------------
    logic             any_match;
    logic [IDX_W-1:0] sel_idx;

    vpt_tlb_prio #(.N_ENT(N_ENT)) u_prio (
        .match_vec (match_vec),
        .any       (any_match),
        .idx       (sel_idx)
    );

    // ---------------- permission and address logic ----------------
    logic            sel_valid, sel_priv, sel_wr;
    logic [1:0]      sel_size;
    logic [VA_W-1:0] sel_mask;
    logic            priv_block, wr_block, lk_fault;
    logic            nx_hit, nx_miss, nx_fault;
    logic [VA_W-1:0] nx_paddr;
    logic            nx_rd, nx_wr, nx_ex;
    logic            fault_evt;

    always_comb begin
        sel_valid  = tte_all[sel_idx][TTE_VALID];
        sel_priv   = tte_all[sel_idx][TTE_PRIV];
        sel_wr     = tte_all[sel_idx][TTE_WRITE];
        sel_size   = tte_all[sel_idx][TTE_SZ_HI:TTE_SZ_LO];
        sel_mask   = page_mask(pg_size_e'(sel_size));
        priv_block = sel_priv && req_user;
        wr_block   = CHECK_WRITE && !sel_wr && req_write;
        lk_fault   = any_match && (!sel_valid || priv_block || wr_block);

        if (!xlat_en) begin
            nx_hit   = 1'b1;
            nx_miss  = 1'b0;
            nx_fault = 1'b0;
            nx_paddr = req_vaddr;
            nx_rd    = CHECK_WRITE;
            nx_wr    = CHECK_WRITE;
            nx_ex    = !CHECK_WRITE;
        end else begin
            nx_hit   = any_match && !lk_fault;
            nx_miss  = !any_match;
            nx_fault = lk_fault;
            nx_paddr = nx_hit ? ((tte_all[sel_idx] & sel_mask & PA_KEEP) |
                                 (req_vaddr & ~sel_mask & PA_KEEP)) : '0;
            nx_rd    = nx_hit && CHECK_WRITE;
            nx_wr    = nx_hit && CHECK_WRITE && sel_wr;
            nx_ex    = nx_hit && !CHECK_WRITE;
        end
        fault_evt = req_valid && xlat_en && lk_fault;
    end

    // ---------------- fault registers ----------------
    vpt_tlb_fault_regs u_fregs (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (fsr_clr),
        .fault_evt (fault_evt),
        .is_user   (req_user),
        .is_write  (CHECK_WRITE && req_write),
        .vaddr     (req_vaddr),
        .fsr_q     (fsr_q),
        .far_q     (far_q)
    );

    // ---------------- response state machine ----------------
    rsp_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid)  state_d = ST_RESP;
            ST_RESP: if (!req_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_paddr <= '0;
            rsp_rd_ok <= 1'b0;
            rsp_wr_ok <= 1'b0;
            rsp_ex_ok <= 1'b0;
        end else if (state_d == ST_RESP) begin
            rsp_hit   <= nx_hit;
            rsp_miss  <= nx_miss;
            rsp_fault <= nx_fault;
            rsp_paddr <= nx_paddr;
            rsp_rd_ok <= nx_rd;
            rsp_wr_ok <= nx_wr;
            rsp_ex_ok <= nx_ex;
        end else begin
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_paddr <= '0;
            rsp_rd_ok <= 1'b0;
            rsp_wr_ok <= 1'b0;
            rsp_ex_ok <= 1'b0;
        end
    end

    assign rsp_valid = (state_q == ST_RESP);

    // ---------------- assertions ----------------
    assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_rsp_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_one_outcome_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_fault}) == 1));

    assert_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault));

    assert_fault_logged_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> fsr_q[0]);

    assert_far_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && xlat_en) |=> (rsp_fault ? (far_q == $past(req_vaddr)) : 1'b1));

    assert_wr_needs_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wr_ok |-> rsp_rd_ok);

    assert_passthru_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !xlat_en) |=> (rsp_hit && rsp_paddr == $past(req_vaddr)));
endmodule

// File: tb/vpt_tlb_bench.sv
`timescale 1ns/1ps
module vpt_tlb_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xlat_en = 1'b0;
    logic [12:0] cur_ctx = 13'd5;
    logic        req_valid = 1'b0;
    logic [63:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault;
    logic [63:0] rsp_paddr;
    logic        rsp_rd_ok, rsp_wr_ok, rsp_ex_ok;
    logic        ent_we = 1'b0;
    logic [5:0]  ent_idx = '0;
    logic [63:0] ent_tag = '0;
    logic [63:0] ent_tte = '0;
    logic [5:0]  ent_rd_idx = '0;
    logic [63:0] ent_rd_tag, ent_rd_tte;
    logic        fsr_clr = 1'b0;
    logic [3:0]  fsr_q;
    logic [63:0] far_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [63:0] V     = 64'h8000_0000_0000_0000;
    localparam logic [63:0] SZ64  = 64'h2000_0000_0000_0000;
    localparam logic [63:0] SZ512 = 64'h4000_0000_0000_0000;
    localparam logic [63:0] SZ4M  = 64'h6000_0000_0000_0000;
    localparam logic [63:0] PRIV  = 64'h4;
    localparam logic [63:0] WRB   = 64'h2;
    localparam logic [63:0] LOCK  = 64'h40;

    always #2.5 clk = ~clk;

    vpt_tlb u_vpt_tlb (
        .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .cur_ctx(cur_ctx),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
        .req_user(req_user), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_miss(rsp_miss), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .rsp_rd_ok(rsp_rd_ok), .rsp_wr_ok(rsp_wr_ok), .rsp_ex_ok(rsp_ex_ok),
        .ent_we(ent_we), .ent_idx(ent_idx), .ent_tag(ent_tag), .ent_tte(ent_tte),
        .ent_rd_idx(ent_rd_idx), .ent_rd_tag(ent_rd_tag), .ent_rd_tte(ent_rd_tte),
        .fsr_clr(fsr_clr), .fsr_q(fsr_q), .far_q(far_q)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr_ent(input logic [5:0] idx, input logic [63:0] tag, input logic [63:0] tte);
        @(negedge clk);
        ent_we = 1'b1; ent_idx = idx; ent_tag = tag; ent_tte = tte;
        @(negedge clk);
        ent_we = 1'b0;
    endtask

    // request driven for one cycle; result is sampled at the negedge after the capture edge
    task automatic lookup(input logic [63:0] va, input logic wr, input logic usr, input logic clr);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = usr; fsr_clr = clr;
        @(negedge clk);
        req_valid = 1'b0; fsr_clr = 1'b0;
    endtask

    task automatic clear_fsr();
        @(negedge clk);
        fsr_clr = 1'b1;
        @(negedge clk);
        fsr_clr = 1'b0;
    endtask

    task automatic expect_hit(input string req, input logic [63:0] pa,
                              input logic rd, input logic wr);
        chk(req, "valid", rsp_valid, 1);
        chk(req, "hit", rsp_hit, 1);
        chk(req, "fault", rsp_fault, 0);
        chk(req, "paddr", rsp_paddr, pa);
        chk(req, "rd_ok", rsp_rd_ok, rd);
        chk(req, "wr_ok", rsp_wr_ok, wr);
    endtask

    task automatic t_reset();
        chk("R1", "valid after reset", rsp_valid, 0);
        chk("R7", "fsr after reset", fsr_q, 0);
        chk("R7", "far after reset", far_q, 0);
    endtask

    task automatic t_sizes();
        lookup(64'h0000_0000_4000_1ABC, 0, 0, 0);
        expect_hit("R2 R3 R5 8K", 64'h0000_0001_2345_7000, 1, 1);
        @(negedge clk);
        chk("R1", "valid drops", rsp_valid, 0);
        chk("R1", "hit drops", rsp_hit, 0);
        lookup(64'h0000_0088_0000_F123, 0, 0, 0);
        expect_hit("R2 R3 R5 64K", 64'h0000_0000_0AB0_F000, 1, 0);
        lookup(64'h0700_0000_0007_1234, 0, 0, 0);
        expect_hit("R2 R3 512K", 64'h0000_0000_0087_1000, 1, 0);
        lookup(64'h0000_1234_003F_F777, 1, 0, 0);
        expect_hit("R2 R3 R5 4M", 64'h0000_0001_803F_F000, 1, 1);
        // 8K entry does not cover a neighbouring 8K page
        lookup(64'h0000_0000_4000_2000, 0, 0, 0);
        chk("R2", "outside page miss", rsp_miss, 1);
    endtask

    task automatic t_ctx_miss();
        cur_ctx = 13'd6;
        lookup(64'h0000_0000_4000_1ABC, 0, 0, 0);
        chk("R2", "ctx mismatch miss", rsp_miss, 1);
        chk("R9", "fsr after miss", fsr_q, 0);
        chk("R9", "far after miss", far_q, 0);
        cur_ctx = 13'd5;
    endtask

    task automatic t_priority();
        lookup(64'h0000_0000_5000_0010, 0, 0, 0);
        expect_hit("R4 lowest wins", 64'h0000_0000_0011_2000, 1, 0);
    endtask

    task automatic t_faults();
        lookup(64'h0000_0000_6000_0040, 0, 0, 0);
        chk("R6", "invalid entry fault", rsp_fault, 1);
        chk("R7", "fsr invalid", fsr_q, 4'h1);
        chk("R7", "far invalid", far_q, 64'h0000_0000_6000_0040);
        clear_fsr();
        chk("R11", "fsr cleared", fsr_q, 0);
        lookup(64'h0000_1234_0000_0010, 0, 1, 0);
        chk("R6", "user on priv page fault", rsp_fault, 1);
        chk("R7", "fsr user fault", fsr_q, 4'h9);
        lookup(64'h0000_0088_0000_0004, 1, 0, 0);
        chk("R6", "write to read-only fault", rsp_fault, 1);
        chk("R8", "fsr overflow", fsr_q, 4'h7);
        chk("R7", "far second fault", far_q, 64'h0000_0088_0000_0004);
        lookup(64'h0000_0000_4000_0008, 1, 1, 0);
        expect_hit("R5 user write ok", 64'h0000_0001_2345_6000, 1, 1);
        chk("R9", "fsr after hit", fsr_q, 4'h7);
        // clear and fault in the same cycle: no overflow
        lookup(64'h0000_0088_0000_0100, 1, 1, 1);
        chk("R11", "fault with clear", rsp_fault, 1);
        chk("R11", "fsr clear+fault", fsr_q, 4'hD);
        clear_fsr();
    endtask

    task automatic t_prio_fault();
        wr_ent(6'd4, 64'h0000_0000_5000_0005, 64'h0000_0000_0011_2000);
        lookup(64'h0000_0000_5000_0010, 0, 0, 0);
        chk("R4", "lowest invalid wins fault", rsp_fault, 1);
        chk("R4", "fsr", fsr_q, 4'h1);
        clear_fsr();
    endtask

    task automatic t_disabled();
        xlat_en = 1'b0;
        lookup(64'hDEAD_BEEF_0000_1234, 1, 1, 0);
        expect_hit("R10 passthru", 64'hDEAD_BEEF_0000_1234, 1, 1);
        lookup(64'h0000_0000_6000_0040, 1, 1, 0);
        chk("R10", "no fault when off", rsp_fault, 0);
        chk("R10", "no miss when off", rsp_miss, 0);
        chk("R10", "fsr unchanged", fsr_q, 0);
        xlat_en = 1'b1;
    endtask

    task automatic t_lock();
        lookup(64'h0000_0000_7000_0800, 0, 0, 0);
        expect_hit("R13 locked hit", 64'h0000_0000_0044_4000, 1, 0);
        ent_rd_idx = 6'd7;
        #1;
        chk("R13", "lock readback", ent_rd_tte, V | LOCK | 64'h0044_4000);
        chk("R13", "tag readback", ent_rd_tag, 64'h0000_0000_7000_0005);
    endtask

    task automatic t_write_timing();
        @(negedge clk);
        ent_we = 1'b1; ent_idx = 6'd8;
        ent_tag = 64'h0000_0000_9000_0005; ent_tte = V | WRB | 64'h0055_6000;
        req_valid = 1'b1; req_vaddr = 64'h0000_0000_9000_0000; req_write = 0; req_user = 0;
        @(negedge clk);
        ent_we = 1'b0; req_valid = 1'b0;
        chk("R12", "same-cycle write unseen", rsp_miss, 1);
        lookup(64'h0000_0000_9000_0000, 0, 0, 0);
        expect_hit("R12 next cycle", 64'h0000_0000_0055_6000, 1, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        xlat_en = 1'b1;
        wr_ent(6'd0, 64'h0000_0000_4000_0005, V | WRB | 64'h0000_0001_2345_6000);
        wr_ent(6'd1, 64'h0000_0088_0000_0005, V | SZ64 | 64'h0000_0000_0AB0_0000);
        wr_ent(6'd2, 64'h0000_1234_0000_0005, V | SZ4M | PRIV | WRB | 64'h0000_2001_8000_0000);
        wr_ent(6'd3, 64'h0700_0000_0000_0005, V | SZ512 | 64'h0000_0000_0080_0000);
        wr_ent(6'd4, 64'h0000_0000_5000_0005, V | 64'h0011_2000);
        wr_ent(6'd5, 64'h0000_0000_5000_0005, V | 64'h0022_4000);
        wr_ent(6'd6, 64'h0000_0000_6000_0005, 64'h0000_0000_0033_0000);
        wr_ent(6'd7, 64'h0000_0000_7000_0005, V | LOCK | 64'h0044_4000);
        t_sizes();
        t_ctx_miss();
        t_priority();
        t_faults();
        t_prio_fault();
        t_disabled();
        t_lock();
        t_write_timing();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule